// File: doc/BRIEF.md
# Frequency-Comparison Lock Detector

This block reports whether a frequency-synthesis loop has settled. It takes the reference clock and the loop's feedback clock as single-cycle enable pulses in one system clock domain. It counts feedback pulses over a window made of a fixed number of reference pulses. When the window closes, it compares that count with the window length. If the difference is no larger than a programmable tolerance, the loop is marked as locked. Otherwise the lock is dropped. Because the window is measured in reference periods, the detector responds faster when the reference frequency is higher.

The lock indication is a status bit that only the block drives. Any change of that bit in either direction can raise a sticky interrupt flag, which software clears with a one-cycle strobe. The block also produces two outputs for clock selection:
- a qualified select that passes a request to run from the synthesized clock only while lock holds;
- a one-cycle loss-of-lock pulse that tells the clock mux to return to the oscillator clock.

Top module: `freq_lock_detect`

## Requirements
- R1: After reset, `lock`, `irq`, `lol` and `clk_ok` are all 0.
- R2: A window closes on the clock edge that samples the WIN-th `ref_tick` since reset or since the previous window closed. A `fb_tick` in that same cycle counts toward the closing window. The new `lock` value is visible right after that edge, and no result is given before the first full window.
- R3: When a window closes with N feedback pulses, `lock` becomes 1 if |N − WIN| ≤ `tol` and 0 otherwise. Between window closures, `lock` does not change.
- R4: The feedback count saturates at 4·WIN−1 rather than wrapping, so a feedback clock that runs far too fast is always judged out of lock.
- R5: `lock` is read-only. A write strobe `stat_wr`, with any `stat_wdata`, leaves `lock` unchanged.
- R6: With `irq_en` = 1, every change of `lock` (0→1 or 1→0) sets `irq` at the same edge. With `irq_en` = 0, a change of `lock` leaves `irq` unchanged.
- R7: `irq` stays set until an `irq_clr` strobe clears it. If a new change of `lock` occurs in the same cycle as the strobe, `irq` stays set.
- R8: `clk_ok` equals `sel_pll` AND `lock`.
- R9: `lol` is a one-cycle pulse that appears when `lock` goes from 1 to 0 while `sel_pll` is 1. When `sel_pll` is 0, `lol` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One pulse per reference clock period |
| fb_tick | input | 1 | One pulse per feedback clock period |
| tol | input | TOLW | Allowed deviation of the feedback count from WIN |
| irq_en | input | 1 | Interrupt enable for lock changes |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq` |
| stat_wr | input | 1 | Write strobe aimed at the lock status (ignored) |
| stat_wdata | input | 1 | Data carried by that write (ignored) |
| sel_pll | input | 1 | Request to run from the synthesized clock |
| lock | output | 1 | Lock status |
| irq | output | 1 | Sticky lock-change interrupt request |
| clk_ok | output | 1 | Qualified synthesized-clock select |
| lol | output | 1 | Loss-of-lock pulse while the synthesized clock is selected |

## Verification
The bench builds the block with WIN = 8 and TOLW = 3. At these values a full measurement lasts only a few hundred cycles, and the tolerance can reach 7. This makes every edge of the band easy to hit: exact match, one count above or below the allowed deviation, a count of zero, and the upper limit of the band. A feedback burst of 100 pulses in one window drives the count well past the 31 saturation point, which checks that the counter clamps instead of wrapping back into the lock band.

// File: rtl/freq_lock_detect.sv
module freq_lock_detect #(
  parameter int WIN  = 64,
  parameter int TOLW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_tick,
  input  logic            fb_tick,
  input  logic [TOLW-1:0] tol,
  input  logic            irq_en,
  input  logic            irq_clr,
  input  logic            stat_wr,
  input  logic            stat_wdata,
  input  logic            sel_pll,
  output logic            lock,
  output logic            irq,
  output logic            clk_ok,
  output logic            lol
);
  localparam int RW = $clog2(WIN);
  localparam int CW = RW + 2;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] WINC = CW'(WIN);

  logic [RW-1:0] ref_cnt;
  logic [CW-1:0] fb_cnt, fb_sum, dev;
  logic win_end, in_tol, flip;

  assign win_end = ref_tick && (ref_cnt == RW'(WIN - 1));
  assign fb_sum  = (fb_tick && fb_cnt != CMAX) ? fb_cnt + 1'b1 : fb_cnt;
  assign dev     = (fb_sum >= WINC) ? fb_sum - WINC : WINC - fb_sum;
  assign in_tol  = {{TOLW{1'b0}}, dev} <= {{CW{1'b0}}, tol};
  assign flip    = win_end && (in_tol != lock);
  assign clk_ok  = sel_pll && lock;

  logic unused_wr;
  assign unused_wr = stat_wr ^ stat_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      fb_cnt  <= '0;
    end else begin
      if (ref_tick) ref_cnt <= win_end ? '0 : ref_cnt + 1'b1;
      fb_cnt <= win_end ? '0 : fb_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0;
      irq  <= 1'b0;
      lol  <= 1'b0;
    end else begin
      if (win_end) lock <= in_tol;
      if (flip && irq_en) irq <= 1'b1;
      else if (irq_clr)   irq <= 1'b0;
      lol <= flip && lock && sel_pll;
    end
  end
endmodule

// File: rtl/freq_lock_detect_chk.sv
module freq_lock_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic irq_en,
  input logic irq_clr,
  input logic sel_pll,
  input logic lock,
  input logic irq,
  input logic clk_ok,
  input logic lol
);
  a_r3_lock_moves_at_window: assert property (@(posedge clk) disable iff (!rst_n)
    (lock != $past(lock)) |-> $past(ref_tick));
  a_r6_irq_needs_enabled_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(irq_en) && lock != $past(lock)));
  a_r7_clear_wins_without_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_clr) |=> (!irq || lock != $past(lock)));
  a_r8_clk_ok_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ok |-> (lock && sel_pll));
  a_r9_lol_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    lol |-> (!lock && $past(lock) && $past(sel_pll)));
  a_r9_lol_single: assert property (@(posedge clk) disable iff (!rst_n)
    lol |=> !lol);
endmodule

bind freq_lock_detect freq_lock_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .irq_en(irq_en),
  .irq_clr(irq_clr), .sel_pll(sel_pll), .lock(lock), .irq(irq),
  .clk_ok(clk_ok), .lol(lol)
);

// File: tb/test_freq_lock_detect.sv
module test_freq_lock_detect;
  localparam int WIN = 8;
  localparam int TOLW = 3;
  localparam int GAP = 19;

  logic clk = 0, rst_n = 0;
  logic ref_tick = 0, fb_tick = 0, irq_en = 0, irq_clr = 0;
  logic stat_wr = 0, stat_wdata = 0, sel_pll = 0;
  logic [TOLW-1:0] tol = '0;
  logic lock, irq, clk_ok, lol;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  freq_lock_detect #(.WIN(WIN), .TOLW(TOLW)) i_freq_lock_detect (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .tol(tol), .irq_en(irq_en), .irq_clr(irq_clr), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .sel_pll(sel_pll), .lock(lock), .irq(irq),
    .clk_ok(clk_ok), .lol(lol)
  );

  // {fb pulses[7:0], tol[2:0], expected lock}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {8'd8,   3'd0, 1'b1}, {8'd9,  3'd0, 1'b0}, {8'd9, 3'd1, 1'b1},
    {8'd5,   3'd2, 1'b0}, {8'd5,  3'd3, 1'b1}, {8'd15, 3'd7, 1'b1},
    {8'd16,  3'd7, 1'b0}, {8'd0,  3'd7, 1'b0}, {8'd1, 3'd7, 1'b1},
    {8'd100, 3'd7, 1'b0}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_win(int n, int nref, bit clr_last);
    int sent = 0;
    for (int k = 0; k < nref; k++) begin
      for (int c = 0; c < GAP; c++) begin
        @(negedge clk);
        ref_tick = 0;
        irq_clr  = 0;
        fb_tick  = (sent < n);
        if (sent < n) sent++;
      end
      @(negedge clk);
      fb_tick  = 0;
      ref_tick = 1;
      irq_clr  = clr_last && (k == nref - 1);
    end
    @(negedge clk);
    ref_tick = 0;
    irq_clr  = 0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic prev;
    repeat (3) @(negedge clk);
    check("R1 lock", lock, 0);
    check("R1 irq", irq, 0);
    check("R1 lol", lol, 0);
    check("R1 clk_ok", clk_ok, 0);
    rst_n = 1;

    run_win(8, WIN - 1, 0);
    check("R2 no result before full window", lock, 0);
    run_win(0, 1, 0);
    check("R2 result after WIN-th ref tick", lock, 1);
    check("R6 irq_en=0 keeps irq clear", irq, 0);

    @(negedge clk); stat_wr = 1; stat_wdata = 0;
    @(negedge clk); stat_wr = 0;
    @(negedge clk);
    check("R5 write ignored", lock, 1);

    sel_pll = 1;
    #1 check("R8 clk_ok with lock", clk_ok, 1);
    run_win(0, WIN, 0);
    check("R9 lol pulse", lol, 1);
    check("R3 zero count drops lock", lock, 0);
    check("R8 clk_ok without lock", clk_ok, 0);
    @(negedge clk);
    check("R9 lol one cycle", lol, 0);
    sel_pll = 0;

    irq_en = 1;
    prev = 0;
    for (int i = 0; i < NV; i++) begin
      tol = VEC[i][3:1];
      run_win(int'(VEC[i][11:4]), WIN, 0);
      check((i == NV - 1) ? "R4 saturated count" : "R3 band", lock, VEC[i][0]);
      check("R6 irq on flip", irq, int'(VEC[i][0] != prev));
      prev = VEC[i][0];
      irq_clr = 1;
      @(negedge clk); irq_clr = 0;
      check("R7 clear", irq, 0);
    end

    tol = 0;
    run_win(8, WIN, 1);
    check("R7 flip beats clear", irq, 1);
    check("R3 relock", lock, 1);
    @(negedge clk);
    check("R7 irq held", irq, 1);
    irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    check("R7 cleared by strobe", irq, 0);

    run_win(0, WIN, 0);
    check("R9 no lol when not selected", lol, 0);
    check("R6 irq on drop", irq, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule